// File: doc/BRIEF.md
# Four-Channel Byte DMA Controller

This block is a bus-master engine that moves single bytes between peripherals and memory on behalf of four independent channels. Each channel keeps a 16-bit current address and a 16-bit transfer count, each shadowed by a base copy written from the CPU. The engine accepts a request from a peripheral line or from a software request bit, asks the system for the bus with a hold request, and waits for the grant. It then runs one bus transfer and gives the bus back. A memory-to-memory transfer is the exception: its read cycle and its write cycle run under one grant.

Every transfer begins with an address phase. In that phase the upper address byte is placed on the shared data output and marked by a latch strobe, and the lower byte goes out on its own pins. A strobe phase follows, and a low ready input can stretch it. The cycle ends with an end phase in which the address increments and the count decrements. A transfer that starts with a count of zero is the terminal one. On the terminal transfer the channel either reloads its base values or masks itself. An external stop input can end a channel's run early in the same way.

The sequencer has five states. IDLE picks the highest-priority eligible channel and goes to HOLD. HOLD waits for the grant and then goes to ADDR. ADDR always goes to ACT. ACT stays in ACT while ready is low and goes to END once ready is high. END goes to ADDR for the write half of a memory-to-memory transfer, and to IDLE otherwise.

Top module: `dma4_engine`

## Requirements
- R1: After reset every output is low, all four mask bits read 1 (register 0x11 reads 0x0F), the status register reads 0, and a request on a masked channel raises no bus request.
- R2: Channel c's registers sit at byte address {0, c[1:0], f[1:0]}, where f=0 is the address low byte, f=1 the address high byte, f=2 the count low byte and f=3 the count high byte. A write loads both the base and the current value. A read returns the current value.
- R3: The engine raises bus_req_o and asserts neither bus_own_o nor any acknowledge until bus_gnt_i has been seen. At most one chan_ack_o bit is high, and it is high only for the serviced channel during the address and strobe phases.
- R4: In the single address phase cycle, addr_latch_o and data_oe_o are high, data_o carries address bits 15:8, and addr_lo_o carries bits 7:0. addr_lo_o stays valid and bus_own_o stays high through the strobe phase.
- R5: Mode register 0x10 takes bits 1:0 as the channel, bit 2 as the direction and bit 3 as auto-reload. Direction 0 asserts io_rd_o with mem_wr_o. Direction 1 asserts mem_rd_o with io_wr_o.
- R6: While ready_i is low in the strobe phase, the strobes and addr_lo_o hold their values. The phase lasts one cycle longer for each low sample.
- R7: Each transfer increments the channel address by 1 (with carry into the upper byte) and decrements the count by 1. A transfer that starts with count 0 is terminal, leaves the count at 0xFFFF, and pulses tc_o for one cycle.
- R8: On completion, a channel with auto-reload restores its base address and count and stays unmasked. A channel without auto-reload sets its own mask bit.
- R9: Priority is fixed with channel 0 highest, and requests are sampled only in IDLE.
- R10: Bits 3:0 written to register 0x12 are software requests that behave like the request lines. A channel's software request bit clears when that channel completes.
- R11: stop_i high during the strobe phase makes that transfer the last one: the channel completes as in R8 and sets its status flag, and tc_o stays low.
- R12: With bit 0 of register 0x13 set, a request on channel 0 reads a byte from channel 0's address into a temporary register and then writes it, driven on data_o with data_oe_o, to channel 1's address under the same grant. Channel 0's count governs completion, and channel 1's request is ignored.
- R13: Reading register 0x10 returns the completion flags in bits 3:0 and the pending requests (line or software) in bits 7:4. That read clears the completion flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register interface select |
| reg_wr_i | input | 1 | Register write |
| reg_rd_i | input | 1 | Register read (has a side effect on status) |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| chan_req_i | input | 4 | Peripheral request lines |
| chan_ack_o | output | 4 | Peripheral acknowledges |
| bus_req_o | output | 1 | Hold request to the bus owner |
| bus_gnt_i | input | 1 | Hold grant |
| bus_own_o | output | 1 | Engine drives the address and strobes |
| addr_latch_o | output | 1 | Upper address byte is valid on data_o |
| addr_lo_o | output | 8 | Address bits 7:0 |
| data_o | output | 8 | Upper address byte, or the write byte for memory-to-memory |
| data_oe_o | output | 1 | data_o is driven |
| data_i | input | 8 | Read data for memory-to-memory |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| ready_i | input | 1 | Low inserts wait states |
| tc_o | output | 1 | Terminal count pulse |
| stop_i | input | 1 | External end of transfer |

## Verification
The hardest case to reach is a stop request that lands inside the strobe phase of a transfer whose count is far from zero. It has to end the channel without a terminal-count pulse, after one decrement only. The stimulus holds ready low so that the engine parks in the strobe phase, waits until the I/O read strobe is visible, and then raises stop and ready in the same cycle. The memory-to-memory path is the other hard case: two transfers alternate read and write cycles under one grant, and the bench checks that every written byte equals the byte returned to the read at the matching source address.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ADDR,
        ST_ACT,
        ST_END
    } seq_state_e;

    localparam logic [1:0] GRP_MODE  = 2'd0;
    localparam logic [1:0] GRP_MASK  = 2'd1;
    localparam logic [1:0] GRP_SWREQ = 2'd2;
    localparam logic [1:0] GRP_CTRL  = 2'd3;

    localparam logic [1:0] FLD_ALO = 2'd0;
    localparam logic [1:0] FLD_AHI = 2'd1;
    localparam logic [1:0] FLD_CLO = 2'd2;
    localparam logic [1:0] FLD_CHI = 2'd3;
endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req_i,
    output logic           valid_o,
    output logic [CHW-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW  = 2 * DW,
    localparam int CHW = $clog2(NCH),
    localparam int RAW = CHW + 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           reg_sel_i,
    input  logic           reg_wr_i,
    input  logic           reg_rd_i,
    input  logic [RAW-1:0] reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    input  logic [NCH-1:0] hw_req_i,
    input  logic           adv_en_i,
    input  logic [CHW-1:0] adv_ch_i,
    input  logic           adv_cnt_i,
    input  logic           fin_en_i,
    input  logic [CHW-1:0] fin_ch_i,
    input  logic           fin_pair_i,
    output logic [AW-1:0]  cur_addr_o [NCH],
    output logic [AW-1:0]  cur_cnt_o  [NCH],
    output logic [NCH-1:0] dir_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] swreq_o,
    output logic           m2m_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0]  base_addr [NCH];
    logic [AW-1:0]  base_cnt  [NCH];
    logic [AW-1:0]  cur_addr  [NCH];
    logic [AW-1:0]  cur_cnt   [NCH];
    logic [NCH-1:0] mask_q, swreq_q, tc_q, dir_q, auto_q;
    logic           m2m_q;

    logic           grp_sel;
    logic [1:0]     fld;
    logic [CHW-1:0] wch;
    logic [CHW-1:0] mch;
    logic           cpu_wr;
    logic           stat_rd;

    assign grp_sel = reg_addr_i[RAW-1];
    assign fld     = reg_addr_i[1:0];
    assign wch     = reg_addr_i[CHW+1:2];
    assign mch     = reg_wdata_i[CHW-1:0];
    assign cpu_wr  = reg_sel_i && reg_wr_i;
    assign stat_rd = reg_sel_i && reg_rd_i && grp_sel && (fld == GRP_MODE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int c = 0; c < NCH; c++) begin
                base_addr[c] <= '0;
                base_cnt[c]  <= '0;
                cur_addr[c]  <= '0;
                cur_cnt[c]   <= '0;
            end
            mask_q  <= '1;
            swreq_q <= '0;
            tc_q    <= '0;
            dir_q   <= '0;
            auto_q  <= '0;
            m2m_q   <= 1'b0;
        end else begin
            if (stat_rd) begin
                tc_q <= '0;
            end
            if (adv_en_i) begin
                cur_addr[adv_ch_i] <= cur_addr[adv_ch_i] + ONE;
                if (adv_cnt_i) begin
                    cur_cnt[adv_ch_i] <= cur_cnt[adv_ch_i] - ONE;
                end
            end
            if (fin_en_i) begin
                tc_q[fin_ch_i]    <= 1'b1;
                swreq_q[fin_ch_i] <= 1'b0;
                if (auto_q[fin_ch_i]) begin
                    cur_addr[fin_ch_i] <= base_addr[fin_ch_i];
                    cur_cnt[fin_ch_i]  <= base_cnt[fin_ch_i];
                    if (fin_pair_i) begin
                        cur_addr[1] <= base_addr[1];
                    end
                end else begin
                    mask_q[fin_ch_i] <= 1'b1;
                end
            end
            if (cpu_wr) begin
                if (!grp_sel) begin
                    unique case (fld)
                        FLD_ALO: begin
                            base_addr[wch][DW-1:0] <= reg_wdata_i;
                            cur_addr[wch][DW-1:0]  <= reg_wdata_i;
                        end
                        FLD_AHI: begin
                            base_addr[wch][AW-1:DW] <= reg_wdata_i;
                            cur_addr[wch][AW-1:DW]  <= reg_wdata_i;
                        end
                        FLD_CLO: begin
                            base_cnt[wch][DW-1:0] <= reg_wdata_i;
                            cur_cnt[wch][DW-1:0]  <= reg_wdata_i;
                        end
                        FLD_CHI: begin
                            base_cnt[wch][AW-1:DW] <= reg_wdata_i;
                            cur_cnt[wch][AW-1:DW]  <= reg_wdata_i;
                        end
                        default: ;
                    endcase
                end else begin
                    unique case (fld)
                        GRP_MODE: begin
                            dir_q[mch]  <= reg_wdata_i[CHW];
                            auto_q[mch] <= reg_wdata_i[CHW+1];
                        end
                        GRP_MASK:  mask_q  <= reg_wdata_i[NCH-1:0];
                        GRP_SWREQ: swreq_q <= reg_wdata_i[NCH-1:0];
                        GRP_CTRL:  m2m_q   <= reg_wdata_i[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (!grp_sel) begin
            unique case (fld)
                FLD_ALO: reg_rdata_o = cur_addr[wch][DW-1:0];
                FLD_AHI: reg_rdata_o = cur_addr[wch][AW-1:DW];
                FLD_CLO: reg_rdata_o = cur_cnt[wch][DW-1:0];
                FLD_CHI: reg_rdata_o = cur_cnt[wch][AW-1:DW];
                default: ;
            endcase
        end else begin
            unique case (fld)
                GRP_MODE: begin
                    reg_rdata_o[NCH-1:0]     = tc_q;
                    reg_rdata_o[2*NCH-1:NCH] = hw_req_i | swreq_q;
                end
                GRP_MASK:  reg_rdata_o[NCH-1:0] = mask_q;
                GRP_SWREQ: reg_rdata_o[NCH-1:0] = swreq_q;
                GRP_CTRL:  reg_rdata_o[0]       = m2m_q;
                default: ;
            endcase
        end
    end

    assign cur_addr_o = cur_addr;
    assign cur_cnt_o  = cur_cnt;
    assign dir_o      = dir_q;
    assign mask_o     = mask_q;
    assign swreq_o    = swreq_q;
    assign m2m_o      = m2m_q;
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW  = 2 * DW,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           pick_valid_i,
    input  logic [CHW-1:0] pick_ch_i,
    input  logic           m2m_i,
    input  logic [AW-1:0]  cur_addr_i [NCH],
    input  logic [AW-1:0]  cur_cnt_i  [NCH],
    input  logic [NCH-1:0] dir_i,
    input  logic           bus_gnt_i,
    input  logic           ready_i,
    input  logic           stop_i,
    input  logic [DW-1:0]  data_i,
    output logic           bus_req_o,
    output logic           bus_own_o,
    output logic           addr_latch_o,
    output logic [DW-1:0]  addr_lo_o,
    output logic [DW-1:0]  data_o,
    output logic           data_oe_o,
    output logic [NCH-1:0] chan_ack_o,
    output logic           mem_rd_o,
    output logic           mem_wr_o,
    output logic           io_rd_o,
    output logic           io_wr_o,
    output logic           tc_o,
    output logic           adv_en_o,
    output logic [CHW-1:0] adv_ch_o,
    output logic           adv_cnt_o,
    output logic           fin_en_o,
    output logic [CHW-1:0] fin_ch_o,
    output logic           fin_pair_o
);
    seq_state_e     state_q;
    logic [CHW-1:0] ch_q;
    logic           pair_q;
    logic           phase_q;
    logic           stop_seen_q;
    logic           exp_held_q;
    logic [DW-1:0]  temp_q;

    logic           wr_half;
    logic           last_end;
    logic           cnt_zero;
    logic           expire;
    logic [AW-1:0]  sel_addr;

    assign wr_half  = pair_q && phase_q;
    assign cnt_zero = (cur_cnt_i[ch_q] == '0);
    assign sel_addr = wr_half ? cur_addr_i[1] : cur_addr_i[ch_q];
    assign last_end = (state_q == ST_END) && !(pair_q && !phase_q);
    assign expire   = pair_q ? exp_held_q : cnt_zero;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            ch_q        <= '0;
            pair_q      <= 1'b0;
            phase_q     <= 1'b0;
            stop_seen_q <= 1'b0;
            exp_held_q  <= 1'b0;
            temp_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_valid_i) begin
                        ch_q        <= pick_ch_i;
                        pair_q      <= m2m_i && (pick_ch_i == '0);
                        phase_q     <= 1'b0;
                        stop_seen_q <= 1'b0;
                        state_q     <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (bus_gnt_i) begin
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= ST_ACT;
                ST_ACT: begin
                    if (stop_i) begin
                        stop_seen_q <= 1'b1;
                    end
                    if (ready_i) begin
                        if (pair_q && !phase_q) begin
                            temp_q <= data_i;
                        end
                        state_q <= ST_END;
                    end
                end
                ST_END: begin
                    if (pair_q && !phase_q) begin
                        phase_q    <= 1'b1;
                        exp_held_q <= cnt_zero;
                        state_q    <= ST_ADDR;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req_o    = 1'b0;
        bus_own_o    = 1'b0;
        addr_latch_o = 1'b0;
        addr_lo_o    = '0;
        data_o       = '0;
        data_oe_o    = 1'b0;
        chan_ack_o   = '0;
        mem_rd_o     = 1'b0;
        mem_wr_o     = 1'b0;
        io_rd_o      = 1'b0;
        io_wr_o      = 1'b0;
        tc_o         = 1'b0;
        adv_en_o     = 1'b0;
        adv_ch_o     = wr_half ? CHW'(1) : ch_q;
        adv_cnt_o    = !wr_half;
        fin_en_o     = 1'b0;
        fin_ch_o     = ch_q;
        fin_pair_o   = pair_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: bus_req_o = 1'b1;
            ST_ADDR: begin
                bus_req_o    = 1'b1;
                bus_own_o    = 1'b1;
                addr_latch_o = 1'b1;
                addr_lo_o    = sel_addr[DW-1:0];
                data_o       = sel_addr[AW-1:DW];
                data_oe_o    = 1'b1;
                chan_ack_o[ch_q] = !pair_q;
            end
            ST_ACT: begin
                bus_req_o = 1'b1;
                bus_own_o = 1'b1;
                addr_lo_o = sel_addr[DW-1:0];
                chan_ack_o[ch_q] = !pair_q;
                if (pair_q) begin
                    mem_rd_o  = !phase_q;
                    mem_wr_o  = phase_q;
                    data_o    = phase_q ? temp_q : '0;
                    data_oe_o = phase_q;
                end else if (dir_i[ch_q]) begin
                    mem_rd_o = 1'b1;
                    io_wr_o  = 1'b1;
                end else begin
                    io_rd_o  = 1'b1;
                    mem_wr_o = 1'b1;
                end
            end
            ST_END: begin
                bus_req_o = 1'b1;
                bus_own_o = 1'b1;
                adv_en_o  = 1'b1;
                fin_en_o  = last_end && (expire || stop_seen_q);
                tc_o      = last_end && expire;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW  = 2 * DW,
    localparam int CHW = $clog2(NCH),
    localparam int RAW = CHW + 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           reg_sel_i,
    input  logic           reg_wr_i,
    input  logic           reg_rd_i,
    input  logic [RAW-1:0] reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    input  logic [NCH-1:0] chan_req_i,
    output logic [NCH-1:0] chan_ack_o,
    output logic           bus_req_o,
    input  logic           bus_gnt_i,
    output logic           bus_own_o,
    output logic           addr_latch_o,
    output logic [DW-1:0]  addr_lo_o,
    output logic [DW-1:0]  data_o,
    output logic           data_oe_o,
    input  logic [DW-1:0]  data_i,
    output logic           mem_rd_o,
    output logic           mem_wr_o,
    output logic           io_rd_o,
    output logic           io_wr_o,
    input  logic           ready_i,
    output logic           tc_o,
    input  logic           stop_i
);
    logic [AW-1:0]  cur_addr [NCH];
    logic [AW-1:0]  cur_cnt  [NCH];
    logic [NCH-1:0] dir, mask, swreq, elig;
    logic           m2m;
    logic           pick_valid;
    logic [CHW-1:0] pick_ch;
    logic           adv_en, adv_cnt, fin_en, fin_pair;
    logic [CHW-1:0] adv_ch, fin_ch;

    always_comb begin
        elig = (chan_req_i | swreq) & ~mask;
        if (m2m) begin
            elig[1] = 1'b0;
        end
    end

    dma4_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_sel_i   (reg_sel_i),
        .reg_wr_i    (reg_wr_i),
        .reg_rd_i    (reg_rd_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .hw_req_i    (chan_req_i),
        .adv_en_i    (adv_en),
        .adv_ch_i    (adv_ch),
        .adv_cnt_i   (adv_cnt),
        .fin_en_i    (fin_en),
        .fin_ch_i    (fin_ch),
        .fin_pair_i  (fin_pair),
        .cur_addr_o  (cur_addr),
        .cur_cnt_o   (cur_cnt),
        .dir_o       (dir),
        .mask_o      (mask),
        .swreq_o     (swreq),
        .m2m_o       (m2m)
    );

    dma4_arb #(.NCH(NCH)) u_arb (
        .req_i   (elig),
        .valid_o (pick_valid),
        .idx_o   (pick_ch)
    );

    dma4_seq #(.NCH(NCH), .DW(DW)) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pick_valid_i (pick_valid),
        .pick_ch_i    (pick_ch),
        .m2m_i        (m2m),
        .cur_addr_i   (cur_addr),
        .cur_cnt_i    (cur_cnt),
        .dir_i        (dir),
        .bus_gnt_i    (bus_gnt_i),
        .ready_i      (ready_i),
        .stop_i       (stop_i),
        .data_i       (data_i),
        .bus_req_o    (bus_req_o),
        .bus_own_o    (bus_own_o),
        .addr_latch_o (addr_latch_o),
        .addr_lo_o    (addr_lo_o),
        .data_o       (data_o),
        .data_oe_o    (data_oe_o),
        .chan_ack_o   (chan_ack_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .io_rd_o      (io_rd_o),
        .io_wr_o      (io_wr_o),
        .tc_o         (tc_o),
        .adv_en_o     (adv_en),
        .adv_ch_o     (adv_ch),
        .adv_cnt_o    (adv_cnt),
        .fin_en_o     (fin_en),
        .fin_ch_o     (fin_ch),
        .fin_pair_o   (fin_pair)
    );
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [NCH-1:0] chan_ack_o,
    input logic           bus_req_o,
    input logic           bus_gnt_i,
    input logic           bus_own_o,
    input logic           addr_latch_o,
    input logic [DW-1:0]  addr_lo_o,
    input logic           data_oe_o,
    input logic           mem_rd_o,
    input logic           mem_wr_o,
    input logic           io_rd_o,
    input logic           io_wr_o,
    input logic           ready_i,
    input logic           tc_o
);
    logic any_strobe;
    assign any_strobe = mem_rd_o || mem_wr_o || io_rd_o || io_wr_o;

    AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(chan_ack_o)); // R3
    AST_OWN_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_own_o) |-> $past(bus_gnt_i)); // R3
    AST_OWN_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_own_o |-> bus_req_o); // R3
    AST_LATCH_DRIVES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_latch_o |-> (data_oe_o && bus_own_o)); // R4
    AST_LATCH_THEN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_latch_o |=> any_strobe); // R4
    AST_STROBE_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_strobe |-> bus_own_o); // R4
    AST_NO_RD_WR_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o) && !(io_rd_o && io_wr_o)); // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_strobe && !ready_i) |=> ($stable({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}) && $stable(addr_lo_o))); // R6
    AST_TC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_o |=> !tc_o); // R7
endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH), .DW(DW)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chan_ack_o   (chan_ack_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_own_o    (bus_own_o),
    .addr_latch_o (addr_latch_o),
    .addr_lo_o    (addr_lo_o),
    .data_oe_o    (data_oe_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .io_rd_o      (io_rd_o),
    .io_wr_o      (io_wr_o),
    .ready_i      (ready_i),
    .tc_o         (tc_o)
);

// File: tb/test_dma4_engine.sv
`timescale 1ns/1ps
module test_dma4_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] chan_req = '0;
    logic [3:0] chan_ack;
    logic       bus_req, bus_gnt = 1'b0, bus_own, addr_latch;
    logic [7:0] addr_lo, data_out, data_in;
    logic       data_oe, mem_rd, mem_wr, io_rd, io_wr;
    logic       ready = 1'b1, tc, stop = 1'b0;

    int checks = 0;
    int errors = 0;
    int xfers = 0;
    int tc_cnt = 0;
    int strobe_cycles = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0]  hi_lat = '0;
    logic [15:0] log_addr [32];
    logic [3:0]  log_kind [32];
    logic [3:0]  log_ack  [32];
    logic [7:0]  log_dout [32];
    logic        log_oe   [32];

    always #5 clk = ~clk;

    assign data_in = addr_lo ^ 8'h5A;

    dma4_engine i_dma4_engine (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .chan_req_i(chan_req), .chan_ack_o(chan_ack),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_own_o(bus_own),
        .addr_latch_o(addr_latch), .addr_lo_o(addr_lo),
        .data_o(data_out), .data_oe_o(data_oe), .data_i(data_in),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .io_rd_o(io_rd), .io_wr_o(io_wr),
        .ready_i(ready), .tc_o(tc), .stop_i(stop)
    );

    // bus monitor and grant model, sampling one ns before each rising edge
    always @(negedge clk) begin
        #4;
        bus_gnt = bus_req;
        if (addr_latch) hi_lat = data_out;
        if (mem_rd || mem_wr || io_rd || io_wr) begin
            strobe_cycles++;
            if (ready && xfers < 32) begin
                log_addr[xfers] = {hi_lat, addr_lo};
                log_kind[xfers] = {mem_rd, mem_wr, io_rd, io_wr};
                log_ack[xfers]  = chan_ack;
                log_dout[xfers] = data_out;
                log_oe[xfers]   = data_oe;
                xfers++;
            end
        end
        if (tc) tc_cnt++;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic prog_ch(input int ch, input logic [15:0] a, input logic [15:0] n,
                           input bit dir, input bit autor);
        wr_reg(5'(ch * 4 + 0), a[7:0]);
        wr_reg(5'(ch * 4 + 1), a[15:8]);
        wr_reg(5'(ch * 4 + 2), n[7:0]);
        wr_reg(5'(ch * 4 + 3), n[15:8]);
        wr_reg(5'h10, {4'h0, autor, dir, 2'(ch)});
    endtask

    task automatic wait_xfers(input int n);
        int guard = 0;
        while (xfers < n && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 bus_req", bus_req, 0);
        chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr, tc, addr_latch}, 0);
        chk("R1 ack", chan_ack, 0);
        rd_reg(5'h11, d);
        chk("R1 mask", d, 8'h0F);
        chan_req = 4'b0001;
        repeat (6) @(negedge clk);
        chk("R1 masked request ignored", bus_req, 0);
        rd_reg(5'h10, d);
        chk("R13 pending bit", d, 8'h10);
        chan_req = 4'b0000;
        rd_reg(5'h10, d);
        chk("R1 status zero", d, 8'h00);
    endtask

    task automatic t_io_to_mem();
        logic [7:0] d;
        int base = xfers;
        int tcb = tc_cnt;
        prog_ch(2, 16'h12FF, 16'h0001, 1'b0, 1'b0);
        rd_reg(5'h08, d); chk("R2 addr lo", d, 8'hFF);
        rd_reg(5'h09, d); chk("R2 addr hi", d, 8'h12);
        rd_reg(5'h0A, d); chk("R2 cnt lo", d, 8'h01);
        wr_reg(5'h11, 8'h0B);
        chan_req = 4'b0100;
        @(negedge clk);
        while (!bus_req) @(negedge clk);
        chk("R3 no ownership before grant", {bus_own, chan_ack}, 0);
        wait_xfers(base + 2);
        chan_req = 4'b0000;
        repeat (4) @(negedge clk);
        chk("R4 first address", log_addr[base], 16'h12FF);
        chk("R7 carry into upper byte", log_addr[base + 1], 16'h1300);
        chk("R5 io to mem strobes", log_kind[base], 4'b0110);
        chk("R3 ack channel 2", log_ack[base], 4'b0100);
        chk("R7 one tc pulse", tc_cnt - tcb, 1);
        rd_reg(5'h0A, d); chk("R7 count wrapped", d, 8'hFF);
        rd_reg(5'h08, d); chk("R7 address advanced", d, 8'h01);
        rd_reg(5'h11, d); chk("R8 self mask", d, 8'h0F);
        rd_reg(5'h10, d); chk("R13 tc flag", d, 8'h04);
        rd_reg(5'h10, d); chk("R13 flag cleared by read", d, 8'h00);
    endtask

    task automatic t_autoreload();
        logic [7:0] d;
        int base = xfers;
        int tcb = tc_cnt;
        prog_ch(3, 16'h4000, 16'h0000, 1'b1, 1'b1);
        wr_reg(5'h11, 8'h07);
        chan_req = 4'b1000;
        wait_xfers(base + 3);
        chan_req = 4'b0000;
        repeat (4) @(negedge clk);
        chk("R8 reload address", log_addr[base + 2], 16'h4000);
        chk("R5 mem to io strobes", log_kind[base + 1], 4'b1001);
        chk("R7 tc each pass", tc_cnt - tcb, 3);
        rd_reg(5'h11, d); chk("R8 stays unmasked", d, 8'h07);
        wr_reg(5'h11, 8'h0F);
        rd_reg(5'h10, d);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        int base = xfers;
        prog_ch(1, 16'h0B00, 16'h0000, 1'b0, 1'b0);
        prog_ch(3, 16'h0C00, 16'h0000, 1'b0, 1'b0);
        wr_reg(5'h11, 8'h05);
        chan_req = 4'b1010;
        wait_xfers(base + 2);
        chan_req = 4'b0000;
        repeat (4) @(negedge clk);
        chk("R9 lower channel first", log_ack[base], 4'b0010);
        chk("R9 first address", log_addr[base], 16'h0B00);
        chk("R9 then channel 3", log_ack[base + 1], 4'b1000);
        rd_reg(5'h10, d);
        chk("R13 two flags", d, 8'h0A);
    endtask

    task automatic t_soft_request();
        logic [7:0] d;
        int base = xfers;
        prog_ch(2, 16'h3300, 16'h0000, 1'b0, 1'b0);
        wr_reg(5'h11, 8'h0B);
        wr_reg(5'h12, 8'h04);
        wait_xfers(base + 1);
        repeat (4) @(negedge clk);
        chk("R10 software start", log_addr[base], 16'h3300);
        chk("R10 ack", log_ack[base], 4'b0100);
        rd_reg(5'h10, d);
        chk("R10 request bit cleared", d, 8'h04);
    endtask

    task automatic t_wait_states();
        logic [7:0] d;
        int base = xfers;
        prog_ch(2, 16'h5000, 16'h0000, 1'b0, 1'b0);
        wr_reg(5'h11, 8'h0B);
        ready = 1'b0;
        strobe_cycles = 0;
        chan_req = 4'b0100;
        while (!io_rd) @(negedge clk);
        chan_req = 4'b0000;
        repeat (3) @(negedge clk);
        ready = 1'b1;
        wait_xfers(base + 1);
        repeat (4) @(negedge clk);
        chk("R6 stretched strobe", strobe_cycles, 4);
        chk("R6 address held", log_addr[base], 16'h5000);
        rd_reg(5'h10, d);
    endtask

    task automatic t_stop();
        logic [7:0] d;
        int base = xfers;
        int tcb = tc_cnt;
        prog_ch(2, 16'h6000, 16'h0005, 1'b0, 1'b0);
        wr_reg(5'h11, 8'h0B);
        ready = 1'b0;
        chan_req = 4'b0100;
        while (!io_rd) @(negedge clk);
        stop = 1'b1;
        ready = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chan_req = 4'b0000;
        repeat (4) @(negedge clk);
        chk("R11 single transfer", xfers - base, 1);
        chk("R11 no tc pulse", tc_cnt - tcb, 0);
        rd_reg(5'h0A, d); chk("R11 count", d, 8'h04);
        rd_reg(5'h11, d); chk("R11 masked", d, 8'h0F);
        rd_reg(5'h10, d); chk("R11 flag", d, 8'h04);
    endtask

    task automatic t_mem_to_mem();
        logic [7:0] d;
        int base = xfers;
        int tcb = tc_cnt;
        prog_ch(0, 16'h0100, 16'h0001, 1'b0, 1'b0);
        prog_ch(1, 16'h0280, 16'h0000, 1'b0, 1'b0);
        wr_reg(5'h13, 8'h01);
        wr_reg(5'h11, 8'h0C);
        wr_reg(5'h12, 8'h01);
        wait_xfers(base + 4);
        repeat (4) @(negedge clk);
        chk("R12 read source", log_addr[base], 16'h0100);
        chk("R12 read strobe", log_kind[base], 4'b1000);
        chk("R12 no ack", log_ack[base], 4'b0000);
        chk("R12 write dest", log_addr[base + 1], 16'h0280);
        chk("R12 write strobe", log_kind[base + 1], 4'b0100);
        chk("R12 byte copied", {log_oe[base + 1], log_dout[base + 1]}, {1'b1, 8'h5A});
        chk("R12 second source", log_addr[base + 2], 16'h0101);
        chk("R12 second copy", {log_addr[base + 3], log_dout[base + 3]}, {16'h0281, 8'h5B});
        chk("R12 four cycles only", xfers - base, 4);
        chk("R12 tc once", tc_cnt - tcb, 1);
        rd_reg(5'h10, d); chk("R12 flag on channel 0", d, 8'h01);
        rd_reg(5'h04, d); chk("R12 dest advanced", d, 8'h82);
        wr_reg(5'h13, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_io_to_mem();
        t_autoreload();
        t_priority();
        t_soft_request();
        t_wait_states();
        t_stop();
        t_mem_to_mem();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule